// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier with Go/Done Handshake

This block multiplies two unsigned operands of `OPW` bits and returns an exact `2*OPW`-bit product. The caller holds operands on `opa`/`opb` and raises `go` while `done` is high. The block then lowers `done`, works for a number of cycles that depends on the operands, and raises `done` again with the product on `acc`. The product stays on `acc` until the next accepted `go`.

Inside, a control FSM drives two small token-driven units. The first is a shift-register unit that holds the multiplicand (`2*OPW` bits wide, so that left shifts lose nothing) and the multiplier. It obeys a load, hold or shift token. The second is an ALU that obeys a zero-test or add token, and one operand port is shared by both functions. The FSM tests the multiplicand and then the multiplier for zero on separate cycles. It leaves as soon as either is zero, so small or zero operands finish early. Each shift step adds the multiplicand into the accumulator when the multiplier's low bit is 1.

Top module: `sam_mult`

## Requirements
- R1: While `rst_n` is low, and from the first cycle after it is released, `done` is 1 and `acc` is 0. A reset applied in the middle of a multiplication aborts it in this way.
- R2: A `go` of 1 sampled while `done` is 1 starts an operation: from the next cycle `done` is 0 and `acc` is 0.
- R3: While `done` is 1 and `go` is 0, `done` stays 1 and `acc` keeps its value whatever `opa` and `opb` do.
- R4: When `done` returns to 1, `acc` equals the exact unsigned product of the `opa` and `opb` sampled with `go`. This holds across the full range, including 255*255 = 65025 at `OPW` = 8.
- R5: If the sampled `opa` is 0, `done` is 0 for exactly 1 cycle and `acc` ends at 0.
- R6: If the sampled `opa` is nonzero and the sampled `opb` is 0, `done` is 0 for exactly 2 cycles and `acc` ends at 0.
- R7: If both sampled operands are nonzero, `done` is 0 for exactly 3*L+2 cycles, where L is the bit position of the highest 1 in `opb` plus one (bit 0 is the least significant).
- R8: Changes on `go`, `opa` and `opb` while `done` is 0 change neither the result nor the number of busy cycles.
- R9: While `done` is 0, `acc` never decreases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled only while `done` is 1 |
| opa | input | OPW | Multiplicand operand |
| opb | input | OPW | Multiplier operand |
| done | output | 1 | High when idle and the result is valid |
| acc | output | 2*OPW | Accumulated product |

## Verification
The bench goes after the early exits. A zero multiplicand must return after one busy cycle and a zero multiplier after two. A design that tested the operands in the wrong order, or skipped the first zero test, would show a different busy count. The operand pairs 255*255 and 128*2 probe a multiplicand register that is too narrow, which would drop the high bits during left shifts and return a truncated product. The bench also wiggles `go` and the operands during a run and applies a reset mid-run: a controller that samples `go` outside idle would restart and report the wrong product, and a reset that failed to clear the accumulator would leave a partial sum on `acc`.

// File: rtl/sam_pkg.sv
`timescale 1ns/1ps
package sam_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ZTEST = 3'd1,
      ST_ZU    = 3'd2,
      ST_ZV    = 3'd3,
      ST_SHIFT = 3'd4
   } sam_state_e;

   typedef enum logic [1:0] {
      SR_HOLD  = 2'd0,
      SR_LOAD  = 2'd1,
      SR_SHIFT = 2'd2
   } sr_op_e;

   typedef enum logic {
      ALU_ZERO = 1'b0,
      ALU_ADD  = 1'b1
   } alu_op_e;

endpackage

// File: rtl/sam_shreg.sv
`timescale 1ns/1ps
module sam_shreg
   import sam_pkg::*;
#(
   parameter int OPW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sr_op_e           op,
   input  logic [OPW-1:0]   ld_a,
   input  logic [OPW-1:0]   ld_b,
   output logic [2*OPW-1:0] u_q,
   output logic [OPW-1:0]   v_q
);
   localparam int UW = 2 * OPW;

   logic [UW-1:0]  u_d;
   logic [OPW-1:0] v_d;

   always_comb begin
      u_d = u_q;
      v_d = v_q;
      case (op)
         SR_LOAD: begin
            u_d = {{OPW{1'b0}}, ld_a};
            v_d = ld_b;
         end
         SR_SHIFT: begin
            u_d = {u_q[UW-2:0], 1'b0};
            v_d = {1'b0, v_q[OPW-1:1]};
         end
         default: begin
            u_d = u_q;
            v_d = v_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         u_q <= '0;
         v_q <= '0;
      end else begin
         u_q <= u_d;
         v_q <= v_d;
      end
   end

endmodule

// File: rtl/sam_alu.sv
`timescale 1ns/1ps
module sam_alu
   import sam_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   opnd1,
   input  logic [W-1:0]   opnd2,
   output logic           is_zero,
   output logic [W-1:0]   sum
);
   always_comb begin
      is_zero = 1'b0;
      sum     = '0;
      case (op)
         ALU_ZERO: is_zero = (opnd1 == '0);
         ALU_ADD:  sum     = opnd1 + opnd2;
         default: begin
            is_zero = 1'b0;
            sum     = '0;
         end
      endcase
   end
endmodule

// File: rtl/sam_ctrl.sv
`timescale 1ns/1ps
module sam_ctrl
   import sam_pkg::*;
#(
   parameter int OPW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [2*OPW-1:0] u_q,
   input  logic [OPW-1:0]   v_q,
   input  logic             alu_zero,
   input  logic [2*OPW-1:0] alu_sum,
   output sr_op_e           sr_op,
   output alu_op_e          alu_op,
   output logic [2*OPW-1:0] alu_opnd1,
   output logic [2*OPW-1:0] alu_opnd2,
   output logic             done,
   output logic [2*OPW-1:0] acc
);
   localparam int PW = 2 * OPW;

   sam_state_e     st_q, st_d;
   logic           acc_clr, acc_ld;

   always_comb begin
      st_d      = st_q;
      sr_op     = SR_HOLD;
      alu_op    = ALU_ZERO;
      alu_opnd1 = '0;
      alu_opnd2 = u_q;
      acc_clr   = 1'b0;
      acc_ld    = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (go) begin
               sr_op   = SR_LOAD;
               acc_clr = 1'b1;
               st_d    = ST_ZTEST;
            end
         end
         ST_ZTEST, ST_ZU: begin
            alu_opnd1 = u_q;
            st_d      = alu_zero ? ST_IDLE : ST_ZV;
         end
         ST_ZV: begin
            alu_opnd1 = {{OPW{1'b0}}, v_q};
            st_d      = alu_zero ? ST_IDLE : ST_SHIFT;
         end
         ST_SHIFT: begin
            alu_op    = ALU_ADD;
            alu_opnd1 = acc;
            sr_op     = SR_SHIFT;
            acc_ld    = v_q[0];
            st_d      = ST_ZU;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         acc  <= '0;
      end else begin
         st_q <= st_d;
         if (acc_clr)     acc <= '0;
         else if (acc_ld) acc <= alu_sum[PW-1:0];
      end
   end

   assign done = (st_q == ST_IDLE);

endmodule

// File: rtl/sam_mult.sv
`timescale 1ns/1ps
module sam_mult
   import sam_pkg::*;
#(
   parameter int OPW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [OPW-1:0]   opa,
   input  logic [OPW-1:0]   opb,
   output logic             done,
   output logic [2*OPW-1:0] acc
);
   localparam int PW = 2 * OPW;

   generate
      if (OPW < 2) begin : g_bad_width
         $error("sam_mult: OPW must be at least 2");
      end
   endgenerate

   sr_op_e         sr_op;
   alu_op_e        alu_op;
   logic [PW-1:0]  u_q;
   logic [OPW-1:0] v_q;
   logic [PW-1:0]  alu_opnd1, alu_opnd2, alu_sum;
   logic           alu_zero;

   sam_shreg #(.OPW(OPW)) u_shreg (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (sr_op),
      .ld_a  (opa),
      .ld_b  (opb),
      .u_q   (u_q),
      .v_q   (v_q)
   );

   sam_alu #(.W(PW)) u_alu (
      .op      (alu_op),
      .opnd1   (alu_opnd1),
      .opnd2   (alu_opnd2),
      .is_zero (alu_zero),
      .sum     (alu_sum)
   );

   sam_ctrl #(.OPW(OPW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .u_q       (u_q),
      .v_q       (v_q),
      .alu_zero  (alu_zero),
      .alu_sum   (alu_sum),
      .sr_op     (sr_op),
      .alu_op    (alu_op),
      .alu_opnd1 (alu_opnd1),
      .alu_opnd2 (alu_opnd2),
      .done      (done),
      .acc       (acc)
   );

endmodule

// File: rtl/sam_mult_chk.sv
`timescale 1ns/1ps
module sam_mult_chk #(
   parameter int OPW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [OPW-1:0]   opa,
   input logic [OPW-1:0]   opb,
   input logic             done,
   input logic [2*OPW-1:0] acc
);
   localparam int PW       = 2 * OPW;
   localparam int BUSY_MAX = 3 * OPW + 2;
   localparam int CW       = $clog2(BUSY_MAX + 2) + 1;

   logic [OPW-1:0] cap_a, cap_b;
   logic [CW-1:0]  busy_cnt;
   logic [PW-1:0]  prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a    <= '0;
         cap_b    <= '0;
         busy_cnt <= '0;
      end else begin
         if (done && go) begin
            cap_a <= opa;
            cap_b <= opb;
         end
         if (done)                              busy_cnt <= '0;
         else if (busy_cnt != {CW{1'b1}})       busy_cnt <= busy_cnt + 1'b1;
      end
   end

   assign prod = PW'(cap_a) * PW'(cap_b);

   AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && go) |=> (!done && acc == '0)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !go) |=> (done && $stable(acc))); // R3
   AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (acc == prod)); // R4
   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (busy_cnt <= CW'(BUSY_MAX - 1))); // R7
   AST_ACC_NONDECR: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (acc >= $past(acc))); // R9

endmodule

bind sam_mult sam_mult_chk #(.OPW(OPW)) u_sam_mult_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .go    (go),
   .opa   (opa),
   .opb   (opb),
   .done  (done),
   .acc   (acc)
);

// File: tb/sam_mult_tb_top.sv
`timescale 1ns/1ps
module sam_mult_tb_top;
   localparam int OPW   = 8;
   localparam int NVEC  = 10;
   localparam int WDOG  = 20000;

   // each entry: {a, b, expected product}
   localparam logic [31:0] VEC [NVEC] = '{
      {8'd3,   8'd5,   16'd15},
      {8'd0,   8'd7,   16'd0},
      {8'd9,   8'd0,   16'd0},
      {8'd255, 8'd255, 16'd65025},
      {8'd1,   8'd1,   16'd1},
      {8'd128, 8'd2,   16'd256},
      {8'd200, 8'd13,  16'd2600},
      {8'd17,  8'd128, 16'd2176},
      {8'd0,   8'd0,   16'd0},
      {8'd255, 8'd1,   16'd255}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           go = 1'b0;
   logic [OPW-1:0] opa = '0;
   logic [OPW-1:0] opb = '0;
   logic           done;
   logic [2*OPW-1:0] acc;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   sam_mult #(.OPW(OPW)) dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .opa   (opa),
      .opb   (opb),
      .done  (done),
      .acc   (acc)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int busy_exp(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
      int len;
      len = 0;
      if (a == '0) return 1;
      if (b == '0) return 2;
      for (int i = 0; i < OPW; i++) if (b[i]) len = i + 1;
      return 3 * len + 2;
   endfunction

   task automatic do_run(input logic [OPW-1:0] ta, input logic [OPW-1:0] tb,
                         input logic [15:0] texp, input bit poke);
      int busy;
      int bexp;
      logic [15:0] prev;
      bit mono;
      string breq;
      @(negedge clk);
      opa = ta; opb = tb; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk(!done && acc == 0, "R2", "start: done/acc after go", {15'd0, done} * 65536 + int'(acc), 0);
      busy = 0; mono = 1'b1; prev = acc;
      while (!done && busy < 200) begin
         busy++;
         if (poke && busy >= 3 && busy <= 5) begin
            opa = 8'hAA; opb = 8'h55; go = 1'b1;
         end else begin
            go = 1'b0;
         end
         @(negedge clk);
         if (!done && acc < prev) mono = 1'b0;
         prev = acc;
      end
      go = 1'b0;
      bexp = busy_exp(ta, tb);
      if (poke)          breq = "R8";
      else if (ta == 0)  breq = "R5";
      else if (tb == 0)  breq = "R6";
      else               breq = "R7";
      chk(done && acc == texp, poke ? "R8" : "R4", "product", int'(acc), int'(texp));
      chk(busy == bexp, breq, "busy cycles", busy, bexp);
      chk(mono, "R9", "acc non-decreasing while busy", int'(mono), 1);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      $display("FAIL R4 watchdog expired actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + 1);
      $finish;
   end

   initial begin
      logic [15:0] held;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(done == 1'b1, "R1", "done in reset", int'(done), 1);
      chk(acc == 0, "R1", "acc in reset", int'(acc), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b1 && acc == 0, "R1", "after release", int'(acc), 0);

      // table of vectors
      for (int i = 0; i < NVEC; i++) begin
         do_run(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], 1'b0);
      end

      // R3: idle hold while operands change and go is low
      held = acc;
      opa = 8'h3C; opb = 8'hC3; go = 1'b0;
      repeat (6) @(negedge clk);
      chk(done == 1'b1, "R3", "done held in idle", int'(done), 1);
      chk(acc == held, "R3", "acc held in idle", int'(acc), int'(held));

      // R8: go and operands wiggled mid-run
      do_run(8'd7, 8'd255, 16'd1785, 1'b1);

      // R1: reset in the middle of a run
      @(negedge clk);
      opa = 8'd255; opb = 8'd255; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(done == 1'b1 && acc == 0, "R1", "mid-run reset acc", int'(acc), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b1, "R1", "idle after mid-run reset", int'(done), 1);

      // run after the aborted one still exact
      do_run(8'd254, 8'd3, 16'd762, 1'b0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule